// File: doc/BRIEF.md
# Fixed-Point Execution Unit with Carry, Overflow and Summary-Overflow Flags

This block is the 32-bit integer arithmetic unit of a processor pipeline. It adds and subtracts, with and without a carry-in. It negates, multiplies (upper half signed or unsigned, lower half with an overflow check) and divides (signed or unsigned). Next to the arithmetic it holds three status bits: carry (CA), overflow (OV) and a sticky summary-overflow (SO). When the caller asks for it, the unit also writes a 4-bit condition code that classifies the result.

An operation starts with a one-cycle `start` pulse that carries the opcode, both operands and the two enables (overflow-enable `oe` and record-enable `rc`). All operations except a regular divide finish one clock later. A regular divide runs a restoring divider, one quotient bit per clock. The operands must stay stable while `busy` is high. Divides by zero, and the signed divide of the most negative value by -1, skip the divider: they return a defined value and finish in one clock.

A small control machine sequences the unit. It has three states:
- `ST_IDLE` accepts work. A start with a regular divide goes to `ST_DIVIDE`. Any other start goes to `ST_FINISH`.
- `ST_DIVIDE` steps the divider and moves to `ST_FINISH` after its last step.
- `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `fxu_core`

## Requirements
- R1: After reset, `result`, `xer_flags` and `cr0` are all zero, and `busy` and `done` are low.
- R2: Opcode encodings are ADD=0, ADDC=1, ADDE=2. Each of them returns the low 32 bits of opa+opb, and ADDE adds the current CA as well. ADDC and ADDE load CA with the carry out of bit 31. ADD leaves CA unchanged.
- R3: Opcode encodings are SUBF=3, SUBFC=4, SUBFE=5. Each of them returns opb + NOT(opa) + c, where c is 1 for SUBF and SUBFC and the current CA for SUBFE. SUBFC and SUBFE load CA with the carry out of bit 31. SUBF leaves CA unchanged.
- R4: For the add and subtract forms with `oe`=1, OV is loaded with 1 when the two summed terms have equal sign bits and the result's sign bit differs from them, and with 0 otherwise. With `oe`=0, OV and SO are unchanged.
- R5: Whenever an operation with `oe`=1 sets OV, SO is also set. SO stays set through later operations and is cleared only by an XER write.
- R6: NEG (opcode 6) returns the two's complement of opa and ignores opb. It overflows only when opa is 0x80000000, and it never changes CA.
- R7: MULHW (7) returns bits 63:32 of the signed 64-bit product, and MULHWU (8) returns bits 63:32 of the unsigned product. Neither changes OV or SO, whatever `oe` is.
- R8: MULLW (9) returns the low 32 bits of the signed product. With `oe`=1 it sets OV exactly when the signed 64-bit product differs from the sign-extension of its low 32 bits.
- R9: DIVW (10) returns the signed quotient truncated toward zero, and DIVWU (11) returns the unsigned quotient. A regular divide raises `done` exactly 33 clocks after the clock edge that accepts `start`, and with `oe`=1 it clears OV.
- R10: A divide by zero (either form), and DIVW of 0x80000000 by 0xFFFFFFFF, return 0xFFFFFFFF if opa bit 31 is 1 and 0 otherwise. They load OV with 1 when `oe`=1 and finish in one clock.
- R11: With `rc`=1, `cr0` takes 0x8 for a negative result, 0x4 for a positive result or 0x2 for a zero result, ORed with the updated SO in bit 0. With `rc`=0, `cr0` holds its value.
- R12: `xer_flags` is {SO, OV, CA, 0}, from bit 3 down to bit 0. `xer_wr` loads SO, OV and CA from `xer_wdata` bits 2, 1 and 0. The write takes effect only in an idle cycle without `start`; at any other time it is ignored.
- R13: A non-divide start raises `done` one clock later, for one cycle. `busy` is high from acceptance until `done` falls. A `start` while busy is ignored. `result` changes only when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 4 | Operation code (see R2, R3, R6 to R10) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| oe | input | 1 | Overflow-enable: allow OV and SO update |
| rc | input | 1 | Record-enable: update `cr0` |
| xer_wr | input | 1 | Write SO, OV and CA from `xer_wdata` |
| xer_wdata | input | 3 | New {SO, OV, CA} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; `result` valid |
| result | output | 32 | Result of the last operation |
| xer_flags | output | 4 | {SO, OV, CA, 0} |
| cr0 | output | 4 | Recorded condition code |

## Verification
The bound checker watches the control and flag rules on every cycle:
- `done` lasts one cycle and an accepted start makes the unit busy.
- `result` moves only with `done`.
- SO never drops without a write, and OV never rises unless SO rises with it.
- The flags stay put in idle cycles without a write.
- The condition code never holds more than one class bit.

The arithmetic itself can only be shown by the bench's directed scenarios. These cover carry and overflow at the sign boundary, the extended forms consuming CA, negation of the most negative value, product overflow at 2^31, quotient signs, the two special divide cases and their short latency, and writes or starts that must be ignored while the divider runs.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_ADDE   = 4'd2,
        OP_SUBF   = 4'd3,
        OP_SUBFC  = 4'd4,
        OP_SUBFE  = 4'd5,
        OP_NEG    = 4'd6,
        OP_MULHW  = 4'd7,
        OP_MULHWU = 4'd8,
        OP_MULLW  = 4'd9,
        OP_DIVW   = 4'd10,
        OP_DIVWU  = 4'd11
    } fxu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_FINISH = 2'd2
    } fxu_state_e;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xer_t;

endpackage

// File: rtl/fxu_adder.sv
module fxu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    // signed overflow: like-signed terms producing a result of the other sign
    assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/fxu_multiplier.sv
module fxu_multiplier #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] hi_s,
    output logic [W-1:0] hi_u,
    output logic [W-1:0] lo,
    output logic         lo_ovf
);
    logic signed [2*W-1:0] ps;

    assign ps     = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    assign hi_s   = ps[2*W-1:W];
    assign lo     = ps[W-1:0];
    // unsigned upper half derived from the signed one, no second multiplier
    assign hi_u   = hi_s + (a[W-1] ? b : '0) + (b[W-1] ? a : '0);
    assign lo_ovf = (ps[2*W-1:W] != {W{ps[W-1]}});
endmodule

// File: rtl/fxu_divider.sv
module fxu_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo_next
);
    logic [W-1:0] rem_q, quo_q, den_q;
    logic [W:0]   shifted, diff;
    logic [W-1:0] rem_next;

    assign shifted = {rem_q, quo_q[W-1]};
    assign diff    = shifted - {1'b0, den_q};

    always_comb begin
        if (!diff[W]) begin
            rem_next = diff[W-1:0];
            quo_next = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_next = shifted[W-1:0];
            quo_next = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
        end else if (step) begin
            rem_q <= rem_next;
            quo_q <= quo_next;
        end
    end
endmodule

// File: rtl/fxu_core.sv
module fxu_core
    import fxu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         oe,
    input  logic         rc,
    input  logic         xer_wr,
    input  logic [2:0]   xer_wdata,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [3:0]   xer_flags,
    output logic [3:0]   cr0
);
    localparam int          CW      = $clog2(W);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    fxu_state_e state_q, state_d;
    fxu_op_e    op_e;
    logic [CW-1:0] cnt_q;
    logic oe_q, rc_q, neg_q;
    logic [W-1:0] result_q;
    logic [3:0]   cr0_q;
    xer_t         xer_q, xer_d;

    logic [W-1:0] ax, ay, sum;
    logic         acin, acout, aovf;
    logic [W-1:0] hi_s, hi_u, lo;
    logic         lo_ovf;
    logic [W-1:0] ex_res, quo_next, div_num, div_den;
    logic         ex_ovf, ex_ca_we, ov_cap, go_div, div_special, div_signed;
    logic         load, commit_fast, commit_div, commit;
    logic [W-1:0] fin_res;
    logic         fin_ovf, fin_oe, fin_rc, fin_cap, fin_ca_we;

    assign op_e = fxu_op_e'(op);

    always_comb begin
        ax = opa; ay = opb; acin = 1'b0;
        case (op_e)
            OP_ADDE:           acin = xer_q.ca;
            OP_SUBF, OP_SUBFC: begin ax = opb; ay = ~opa; acin = 1'b1;     end
            OP_SUBFE:          begin ax = opb; ay = ~opa; acin = xer_q.ca; end
            OP_NEG:            begin ax = '0;  ay = ~opa; acin = 1'b1;     end
            default: ;
        endcase
    end

    fxu_adder #(.W(W)) u_add (
        .x(ax), .y(ay), .cin(acin), .sum(sum), .cout(acout), .ovf(aovf)
    );

    fxu_multiplier #(.W(W)) u_mul (
        .a(opa), .b(opb), .hi_s(hi_s), .hi_u(hi_u), .lo(lo), .lo_ovf(lo_ovf)
    );

    assign div_signed  = (op_e == OP_DIVW);
    assign div_special = (opb == '0) || (div_signed && opa == MOST_NEG && opb == '1);
    assign div_num     = (div_signed && opa[W-1]) ? -opa : opa;
    assign div_den     = (div_signed && opb[W-1]) ? -opb : opb;

    always_comb begin
        ex_res = sum; ex_ovf = aovf; ex_ca_we = 1'b0; ov_cap = 1'b1; go_div = 1'b0;
        unique case (op_e)
            OP_ADD, OP_SUBF, OP_NEG: ;
            OP_ADDC, OP_ADDE, OP_SUBFC, OP_SUBFE: ex_ca_we = 1'b1;
            OP_MULHW:  begin ex_res = hi_s; ov_cap = 1'b0; end
            OP_MULHWU: begin ex_res = hi_u; ov_cap = 1'b0; end
            OP_MULLW:  begin ex_res = lo;   ex_ovf = lo_ovf; end
            OP_DIVW, OP_DIVWU: begin
                ex_res = {W{opa[W-1]}};
                ex_ovf = div_special;
                go_div = !div_special;
            end
            default: begin ex_res = '0; ex_ovf = 1'b0; ov_cap = 1'b0; end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = go_div ? ST_DIVIDE : ST_FINISH;
            ST_DIVIDE: if (cnt_q == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign load        = (state_q == ST_IDLE) && start && go_div;
    assign commit_fast = (state_q == ST_IDLE) && start && !go_div;
    assign commit_div  = (state_q == ST_DIVIDE) && (cnt_q == '0);
    assign commit      = commit_fast || commit_div;

    fxu_divider #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(load), .step(state_q == ST_DIVIDE),
        .num(div_num), .den(div_den), .quo_next(quo_next)
    );

    assign fin_res   = commit_div ? (neg_q ? -quo_next : quo_next) : ex_res;
    assign fin_ovf   = commit_div ? 1'b0 : ex_ovf;
    assign fin_oe    = commit_div ? oe_q : oe;
    assign fin_rc    = commit_div ? rc_q : rc;
    assign fin_cap   = commit_div ? 1'b1 : ov_cap;
    assign fin_ca_we = commit_div ? 1'b0 : ex_ca_we;

    always_comb begin
        xer_d.so = xer_q.so | (fin_oe & fin_cap & fin_ovf);
        xer_d.ov = (fin_oe & fin_cap) ? fin_ovf : xer_q.ov;
        xer_d.ca = fin_ca_we ? acout : xer_q.ca;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            rc_q    <= 1'b0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q <= CW'(W - 1);
                oe_q  <= oe;
                rc_q  <= rc;
                neg_q <= div_signed && (opa[W-1] ^ opb[W-1]);
            end else if (state_q == ST_DIVIDE) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // architectural outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            xer_q    <= '0;
            cr0_q    <= '0;
        end else if (commit) begin
            result_q <= fin_res;
            xer_q    <= xer_d;
            if (fin_rc)
                cr0_q <= {fin_res[W-1], !fin_res[W-1] && (fin_res != '0),
                          fin_res == '0, xer_d.so};
        end else if (xer_wr && state_q == ST_IDLE && !start) begin
            xer_q <= xer_t'(xer_wdata);
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign result    = result_q;
    assign xer_flags = {xer_q.so, xer_q.ov, xer_q.ca, 1'b0};
    assign cr0       = cr0_q;
endmodule

// File: rtl/fxu_core_chk.sv
module fxu_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         xer_wr,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [3:0]   xer_flags,
    input logic [3:0]   cr0
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R13
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R13
    AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done); // R13
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (xer_flags[3] && !xer_wr) |=> xer_flags[3]); // R5
    AST_OV_RAISES_SO: assert property (@(posedge clk) disable iff (!rst_n) ($rose(xer_flags[2]) && !$past(xer_wr)) |-> xer_flags[3]); // R5
    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start && !xer_wr) |=> $stable(xer_flags)); // R12
    AST_CR0_CLASS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cr0[3:1])); // R11
endmodule

bind fxu_core fxu_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .xer_wr(xer_wr), .busy(busy),
    .done(done), .result(result), .xer_flags(xer_flags), .cr0(cr0)
);

// File: tb/fxu_core_tb.sv
`timescale 1ns/1ps
module fxu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        oe = 1'b0, rc = 1'b0, xer_wr = 1'b0;
    logic [2:0]  xer_wdata = '0;
    logic        busy, done;
    logic [31:0] result;
    logic [3:0]  xer_flags, cr0;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    fxu_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .oe(oe), .rc(rc), .xer_wr(xer_wr), .xer_wdata(xer_wdata),
        .busy(busy), .done(done), .result(result), .xer_flags(xer_flags), .cr0(cr0)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exec(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic oe_i, input logic rc_i, output int lat);
        @(negedge clk);
        op = o; opa = a; opb = b; oe = oe_i; rc = rc_i; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic xwrite(input logic [2:0] d);
        @(negedge clk);
        xer_wr = 1'b1; xer_wdata = d;
        @(negedge clk);
        xer_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 result", result, 0);
        chk("R1 xer", {28'd0, xer_flags}, 0);
        chk("R1 cr0", {28'd0, cr0}, 0);
        chk("R1 busy/done", {30'd0, busy, done}, 0);
    endtask

    task automatic t_add;
        int lat;
        exec(0, 5, 7, 0, 0, lat);
        chk("R2 add", result, 12);
        chk("R13 single-cycle latency", lat, 1);
        exec(1, 32'hFFFFFFFF, 1, 0, 0, lat);
        chk("R2 addc result", result, 0);
        chk("R2 addc carry", {28'd0, xer_flags}, 4'h2);
        exec(0, 1, 1, 0, 0, lat);
        chk("R2 add keeps CA", {28'd0, xer_flags}, 4'h2);
        exec(2, 1, 1, 0, 0, lat);
        chk("R2 adde uses CA", result, 3);
        chk("R2 adde clears CA", {28'd0, xer_flags}, 4'h0);
    endtask

    task automatic t_sub;
        int lat;
        xwrite(3'b000);
        exec(3, 3, 10, 0, 0, lat);
        chk("R3 subf", result, 7);
        exec(4, 10, 3, 0, 0, lat);
        chk("R3 subfc borrow result", result, 32'hFFFFFFF9);
        chk("R3 subfc borrow CA=0", {28'd0, xer_flags}, 4'h0);
        exec(5, 5, 5, 0, 0, lat);
        chk("R3 subfe CA=0", result, 32'hFFFFFFFF);
        exec(4, 3, 10, 0, 0, lat);
        chk("R3 subfc CA=1", {28'd0, xer_flags}, 4'h2);
        exec(5, 5, 5, 0, 0, lat);
        chk("R3 subfe CA=1 result", result, 0);
        chk("R3 subfe CA=1 carry", {28'd0, xer_flags}, 4'h2);
    endtask

    task automatic t_ovf;
        int lat;
        xwrite(3'b000);
        exec(0, 32'h7FFFFFFF, 1, 1, 0, lat);
        chk("R4 add overflow", {28'd0, xer_flags}, 4'hC);
        exec(0, 1, 1, 1, 0, lat);
        chk("R5 OV clear SO sticky", {28'd0, xer_flags}, 4'h8);
        exec(0, 32'h7FFFFFFF, 1, 0, 0, lat);
        chk("R4 oe=0 no flag change", {28'd0, xer_flags}, 4'h8);
        exec(3, 1, 32'h80000000, 1, 0, lat);
        chk("R4 subf overflow result", result, 32'h7FFFFFFF);
        chk("R4 subf overflow flags", {28'd0, xer_flags}, 4'hC);
        xwrite(3'b000);
        chk("R5 write clears SO", {28'd0, xer_flags}, 4'h0);
    endtask

    task automatic t_neg;
        int lat;
        exec(6, 32'h80000000, 32'h1234, 1, 0, lat);
        chk("R6 neg min result", result, 32'h80000000);
        chk("R6 neg min OV", {28'd0, xer_flags}, 4'hC);
        xwrite(3'b001);
        exec(6, 5, 32'h1234, 1, 0, lat);
        chk("R6 neg result", result, 32'hFFFFFFFB);
        chk("R6 neg no OV CA kept", {28'd0, xer_flags}, 4'h2);
        exec(6, 0, 32'h1234, 1, 0, lat);
        chk("R6 neg zero keeps CA", {28'd0, xer_flags}, 4'h2);
    endtask

    task automatic t_mul;
        int lat;
        xwrite(3'b000);
        exec(7, 32'hFFFFFFFF, 2, 1, 0, lat);
        chk("R7 mulhw negative", result, 32'hFFFFFFFF);
        exec(8, 32'hFFFFFFFF, 2, 1, 0, lat);
        chk("R7 mulhwu", result, 1);
        exec(7, 32'h40000000, 4, 1, 0, lat);
        chk("R7 mulhw 2^32", result, 1);
        chk("R7 oe ignored", {28'd0, xer_flags}, 4'h0);
        exec(9, 32'h8000, 32'h10000, 1, 0, lat);
        chk("R8 mullw 2^31 result", result, 32'h80000000);
        chk("R8 mullw 2^31 overflow", {28'd0, xer_flags}, 4'hC);
        exec(9, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, lat);
        chk("R8 mullw -1*-1", result, 1);
        chk("R8 mullw no overflow", {28'd0, xer_flags}, 4'h8);
    endtask

    task automatic t_div;
        int lat;
        xwrite(3'b000);
        exec(10, 100, 7, 1, 0, lat);
        chk("R9 divw result", result, 14);
        chk("R9 divw latency", lat, 33);
        exec(10, 32'hFFFFFF9C, 7, 1, 0, lat);
        chk("R9 divw -100/7", result, 32'hFFFFFFF2);
        exec(10, 100, 32'hFFFFFFF9, 1, 0, lat);
        chk("R9 divw 100/-7", result, 32'hFFFFFFF2);
        exec(10, 32'hFFFFFF9C, 32'hFFFFFFF9, 1, 0, lat);
        chk("R9 divw -100/-7", result, 14);
        exec(11, 32'hFFFFFFFF, 2, 1, 0, lat);
        chk("R9 divwu", result, 32'h7FFFFFFF);
        exec(11, 32'h80000000, 32'hFFFFFFFF, 1, 0, lat);
        chk("R9 divwu min/max", result, 0);
        chk("R9 divwu regular latency", lat, 33);
        chk("R9 divide no OV", {28'd0, xer_flags}, 4'h0);
    endtask

    task automatic t_div_special;
        int lat;
        exec(10, 32'h80000000, 32'hFFFFFFFF, 1, 0, lat);
        chk("R10 divw min/-1 result", result, 32'hFFFFFFFF);
        chk("R10 divw min/-1 flags", {28'd0, xer_flags}, 4'hC);
        chk("R10 special latency", lat, 1);
        xwrite(3'b000);
        exec(10, 5, 0, 1, 0, lat);
        chk("R10 divw by zero positive", result, 0);
        chk("R10 divw by zero flags", {28'd0, xer_flags}, 4'hC);
        exec(11, 32'h90000000, 0, 1, 0, lat);
        chk("R10 divwu by zero top bit", result, 32'hFFFFFFFF);
    endtask

    task automatic t_cr0;
        int lat;
        xwrite(3'b000);
        exec(0, 32'hFFFFFFFF, 0, 0, 1, lat);
        chk("R11 negative", {28'd0, cr0}, 4'h8);
        exec(0, 1, 0, 0, 1, lat);
        chk("R11 positive", {28'd0, cr0}, 4'h4);
        exec(0, 0, 0, 0, 1, lat);
        chk("R11 zero", {28'd0, cr0}, 4'h2);
        exec(0, 32'h7FFFFFFF, 1, 1, 1, lat);
        chk("R11 negative with SO", {28'd0, cr0}, 4'h9);
        exec(0, 1, 1, 0, 0, lat);
        chk("R11 rc=0 holds", {28'd0, cr0}, 4'h9);
    endtask

    task automatic t_xer;
        xwrite(3'b111);
        chk("R12 write all", {28'd0, xer_flags}, 4'hE);
        xwrite(3'b010);
        chk("R12 write OV only", {28'd0, xer_flags}, 4'h4);
        xwrite(3'b000);
        @(negedge clk);
        op = 0; opa = 1; opb = 1; oe = 0; rc = 0; start = 1'b1;
        xer_wr = 1'b1; xer_wdata = 3'b111;
        @(negedge clk);
        start = 1'b0; xer_wr = 1'b0;
        chk("R12 write ignored with start", {28'd0, xer_flags}, 4'h0);
        chk("R13 done after start", {31'd0, done}, 1);
    endtask

    task automatic t_handshake;
        int lat;
        @(negedge clk);
        op = 10; opa = 100; opb = 7; oe = 0; rc = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (lat == 5) begin start = 1'b1; xer_wr = 1'b1; xer_wdata = 3'b111; end
            else begin start = 1'b0; xer_wr = 1'b0; end
            if (lat == 10) chk("R13 busy during divide", {31'd0, busy}, 1);
            @(negedge clk);
            lat++;
        end
        start = 1'b0; xer_wr = 1'b0;
        chk("R13 restart ignored latency", lat, 33);
        chk("R13 restart ignored result", result, 14);
        chk("R12 write ignored while busy", {28'd0, xer_flags}, 4'h0);
        @(negedge clk);
        chk("R13 idle after done", {30'd0, busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_ovf();
        t_neg();
        t_mul();
        t_div();
        t_div_special();
        t_cr0();
        t_xer();
        t_handshake();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule